// File: doc/BRIEF.md
# UART Fractional Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling tick that a UART's serial logic uses, plus a bit-rate strobe at one sixteenth of that tick rate. The reference clock first passes through an integer predivider whose ratio is selected by a 3-bit code. The predivided clock then drives a fractional stage. That stage is an accumulator which adds (increment+1) on every predivided clock. Whenever the sum reaches (modulus+1) or more, it subtracts (modulus+1) and emits one 16x tick. The resulting bit rate is (reference / predivide / 16) x (increment+1) / (modulus+1). Because the increment already includes the oversampling, an increment of 15 with a predivide of 1 gives a bit rate of reference / (modulus+1).

The host programs the block through three single-cycle write strobes that share one data bus. A small two-state sequencer guards the increment/modulus pair. In state `CFG_IDLE`, an increment write stages the value and moves to `CFG_PAIR_OPEN`; a modulus write or a predivider write stays in `CFG_IDLE` and commits no fractional setting. In `CFG_PAIR_OPEN`, three transitions are possible:
- A modulus write commits both registers and returns to `CFG_IDLE`.
- Another increment write restages the increment and stays in `CFG_PAIR_OPEN`.
- A predivider write cancels the pending pair and returns to `CFG_IDLE`.

Cycles with no strobe keep the current state. The host asserts at most one strobe per cycle; if several strobes are asserted together, the predivider strobe wins over the increment strobe, which wins over the modulus strobe. Every commit and every predivider write restarts the predivide counter, the accumulator and the tick counter.

Top module: `uart_baud_tick`

## Requirements
- R1: After reset the predivider code is 5, the increment is 15 and the modulus is 207. With these values, counting the first clock edge after reset release as cycle 1, the first 16x tick is high in cycle 13, a tick follows every 13 cycles, and the first bit strobe is high in cycle 208. Both outputs are low while reset is held.
- R2: The predivider code (bits [2:0] of `wdata` on a predivider write) maps to these divide values: code 0 → 6, 1 → 5, 2 → 4, 3 → 3, 4 → 2, 5 → 1, 6 → 7, 7 → 1.
- R3: When (increment+1) ≤ (modulus+1), the number of ticks after s predivided clocks, counted from a restart, is floor(s·(increment+1)/(modulus+1)).
- R4: The bit strobe is high only together with a tick, on every 16th tick counted from a restart.
- R5: A modulus write commits a new setting only when the previous register write was an increment write. That write must be to the increment register and not the predivider, though idle cycles between the two writes are allowed. The committed increment is the last one written. A lone modulus write leaves the output rate unchanged.
- R6: An increment write followed by a predivider write commits nothing, and a later lone modulus write still commits nothing.
- R7: A restart takes effect at the clock edge that samples the strobe, and the tick is low in the following cycle. The first tick at the new setting comes exactly ceil((modulus+1)/(increment+1))·D cycles after that edge, where D is the predivide value.
- R8: A predivider write takes effect at once and restarts the counters, while keeping the active increment and modulus.
- R9: When (increment+1) > (modulus+1), a tick is emitted on every predivided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_pdiv | input | 1 | Write strobe for the predivider code (wdata[2:0]) |
| wr_inc | input | 1 | Write strobe for the increment register |
| wr_mod | input | 1 | Write strobe for the modulus register |
| wdata | input | CNT_W (16) | Write data shared by the three strobes |
| tick_16x | output | 1 | One-cycle 16x oversampling tick |
| bit_stb | output | 1 | One-cycle bit-rate strobe, on every 16th tick |

## Verification
A wrong accumulator remainder, predivide count or pairing state shows up at the ports as a shifted first tick after a restart, or as a tick count over a fixed window that is off by one or more. The shifted first tick is visible within ceil((modulus+1)/(increment+1))·D cycles of the restart. The bench therefore restarts the block before each measurement, so the block's phase is known exactly. It then compares the index of the first tick and the tick and strobe counts against values computed arithmetically. The bench sweeps all eight predivider codes and several increment/modulus ratios, including equal values and an increment larger than the modulus. A corrupted tick counter misplaces the bit strobe relative to the tick, which the bench detects on the first strobe after the restart.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int PDIV_CODE_W = 3;
    localparam int PDIV_CNT_W  = 3;

    typedef enum logic {
        CFG_IDLE,
        CFG_PAIR_OPEN
    } cfg_state_e;

    // Integer predivide ratio selected by the 3-bit code (R2)
    function automatic logic [PDIV_CNT_W-1:0] pdiv_ratio(input logic [PDIV_CODE_W-1:0] code);
        logic [PDIV_CNT_W-1:0] r;
        unique case (code)
            3'd0:    r = 3'd6;
            3'd1:    r = 3'd5;
            3'd2:    r = 3'd4;
            3'd3:    r = 3'd3;
            3'd4:    r = 3'd2;
            3'd5:    r = 3'd1;
            3'd6:    r = 3'd7;
            default: r = 3'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ubt_cfg.sv
module ubt_cfg
    import ubt_pkg::*;
#(
    parameter int                    CNT_W    = 16,
    parameter logic [CNT_W-1:0]      RST_INC  = 15,
    parameter logic [CNT_W-1:0]      RST_MOD  = 207,
    parameter logic [PDIV_CODE_W-1:0] RST_PDIV = 3'd5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_pdiv,
    input  logic                   wr_inc,
    input  logic                   wr_mod,
    input  logic [CNT_W-1:0]       wdata,
    output logic [PDIV_CODE_W-1:0] pdiv_code,
    output logic [CNT_W-1:0]       inc_act,
    output logic [CNT_W-1:0]       mod_act,
    output logic                   restart,
    output logic                   pair_open
);

    cfg_state_e       state_q, state_d;
    logic [CNT_W-1:0] inc_stage_q;
    logic             stage_load;
    logic             commit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: begin
                if (wr_pdiv)     state_d = CFG_IDLE;
                else if (wr_inc) state_d = CFG_PAIR_OPEN;
            end
            CFG_PAIR_OPEN: begin
                if (wr_pdiv)     state_d = CFG_IDLE;
                else if (wr_inc) state_d = CFG_PAIR_OPEN;
                else if (wr_mod) state_d = CFG_IDLE;
            end
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        stage_load = 1'b0;
        commit     = 1'b0;
        unique case (state_q)
            CFG_IDLE: begin
                stage_load = !wr_pdiv && wr_inc;
            end
            CFG_PAIR_OPEN: begin
                stage_load = !wr_pdiv && wr_inc;
                commit     = !wr_pdiv && !wr_inc && wr_mod;
            end
        endcase
    end

    assign restart   = commit || wr_pdiv;
    assign pair_open = (state_q == CFG_PAIR_OPEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_stage_q <= RST_INC;
            inc_act     <= RST_INC;
            mod_act     <= RST_MOD;
            pdiv_code   <= RST_PDIV;
        end else begin
            if (stage_load) inc_stage_q <= wdata;
            if (commit) begin
                inc_act <= inc_stage_q;
                mod_act <= wdata;
            end
            if (wr_pdiv) pdiv_code <= wdata[PDIV_CODE_W-1:0];
        end
    end

endmodule

// File: rtl/ubt_prediv.sv
module ubt_prediv
    import ubt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic [PDIV_CODE_W-1:0] pdiv_code,
    output logic                   pre_en
);

    logic [PDIV_CNT_W-1:0] cnt_q;
    logic [PDIV_CNT_W-1:0] ratio;

    assign ratio  = pdiv_ratio(pdiv_code);
    assign pre_en = (cnt_q == ratio - 3'd1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (pre_en)       cnt_q <= '0;
        else                   cnt_q <= cnt_q + 3'd1;
    end

endmodule

// File: rtl/ubt_frac.sv
module ubt_frac #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_en,
    input  logic [CNT_W-1:0] inc_act,
    input  logic [CNT_W-1:0] mod_act,
    output logic             tick,
    output logic [CNT_W:0]   acc
);

    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] inc1, mod1, sum, rem;
    logic [CNT_W:0]   acc_d;
    logic             tick_d;

    assign inc1 = SUM_W'(inc_act) + SUM_W'(1);
    assign mod1 = SUM_W'(mod_act) + SUM_W'(1);
    assign sum  = SUM_W'(acc) + inc1;

    always_comb begin
        rem    = sum - mod1;
        acc_d  = acc;
        tick_d = 1'b0;
        if (pre_en) begin
            if (sum >= mod1) begin
                tick_d = 1'b1;
                // Cap the remainder so the rate saturates at one tick per step
                if (rem >= mod1) rem = SUM_W'(mod_act);
                acc_d = rem[CNT_W:0];
            end else begin
                acc_d = sum[CNT_W:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= acc_d;
            tick <= tick_d;
        end
    end

endmodule

// File: rtl/ubt_bitcnt.sv
module ubt_bitcnt #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic bit_stb
);

    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam logic [OS_W-1:0] LAST = OS_W'(OVERSAMPLE - 1);

    logic [OS_W-1:0] cnt_q;

    assign bit_stb = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (bit_stb)      cnt_q <= '0;
        else if (tick)         cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/uart_baud_tick.sv
module uart_baud_tick
    import ubt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pdiv,
    input  logic             wr_inc,
    input  logic             wr_mod,
    input  logic [CNT_W-1:0] wdata,
    output logic             tick_16x,
    output logic             bit_stb
);

    logic [PDIV_CODE_W-1:0] pdiv_code;
    logic [CNT_W-1:0]       inc_act, mod_act;
    logic                   restart, pair_open, pre_en;
    logic [CNT_W:0]         acc_w;

    ubt_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pdiv   (wr_pdiv),
        .wr_inc    (wr_inc),
        .wr_mod    (wr_mod),
        .wdata     (wdata),
        .pdiv_code (pdiv_code),
        .inc_act   (inc_act),
        .mod_act   (mod_act),
        .restart   (restart),
        .pair_open (pair_open)
    );

    ubt_prediv u_prediv (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .pdiv_code (pdiv_code),
        .pre_en    (pre_en)
    );

    ubt_frac #(.CNT_W(CNT_W)) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pre_en  (pre_en),
        .inc_act (inc_act),
        .mod_act (mod_act),
        .tick    (tick_16x),
        .acc     (acc_w)
    );

    ubt_bitcnt #(.OVERSAMPLE(OVERSAMPLE)) u_bitcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick_16x),
        .bit_stb (bit_stb)
    );

endmodule

// File: rtl/uart_baud_tick_chk.sv
module uart_baud_tick_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_pdiv,
    input logic             wr_inc,
    input logic             wr_mod,
    input logic             pair_open,
    input logic [CNT_W-1:0] inc_act,
    input logic [CNT_W-1:0] mod_act,
    input logic [CNT_W:0]   acc,
    input logic             pre_en,
    input logic             restart,
    input logic             tick_16x,
    input logic             bit_stb
);

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= {1'b0, mod_act}); // R3

    AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_16x |-> $past(pre_en)); // R3

    AST_STB_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> tick_16x); // R4

    AST_LONE_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && !wr_inc && !wr_pdiv && !pair_open) |=> $stable(mod_act) && $stable(inc_act)); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick_16x && !bit_stb); // R7

    AST_FAST_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !restart && (inc_act > mod_act)) |=> tick_16x); // R9

endmodule

bind uart_baud_tick uart_baud_tick_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pdiv   (wr_pdiv),
    .wr_inc    (wr_inc),
    .wr_mod    (wr_mod),
    .pair_open (pair_open),
    .inc_act   (inc_act),
    .mod_act   (mod_act),
    .acc       (acc_w),
    .pre_en    (pre_en),
    .restart   (restart),
    .tick_16x  (tick_16x),
    .bit_stb   (bit_stb)
);

// File: tb/uart_baud_tick_bench.sv
`timescale 1ns/1ps
module uart_baud_tick_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_pdiv = 1'b0, wr_inc = 1'b0, wr_mod = 1'b0;
    logic [15:0] wdata = '0;
    logic        tick, stb;

    int checks = 0;
    int errors = 0;

    // Bench model of the active setting
    int m_code = 5, m_inc = 15, m_mod = 207;

    always #5 clk = ~clk;

    uart_baud_tick u_uart_baud_tick (
        .clk(clk), .rst_n(rst_n), .wr_pdiv(wr_pdiv), .wr_inc(wr_inc),
        .wr_mod(wr_mod), .wdata(wdata), .tick_16x(tick), .bit_stb(stb)
    );

    function automatic int ratio_of(input int code);
        int tbl [8] = '{6, 5, 4, 3, 2, 1, 7, 1};
        return tbl[code];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input int kind, input int val);
        @(negedge clk);
        wdata = 16'(val);
        wr_pdiv = (kind == 0);
        wr_inc  = (kind == 1);
        wr_mod  = (kind == 2);
        @(negedge clk);
        wr_pdiv = 1'b0; wr_inc = 1'b0; wr_mod = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Observe m cycles after a restart and compare with the model
    task automatic measure(input int m, input string tag);
        int d, inc1, mod1, steps, et, ej, ef;
        int first, nt, ns, bad;
        d = ratio_of(m_code);
        inc1 = m_inc + 1;
        mod1 = m_mod + 1;
        steps = m / d;
        if (inc1 >= mod1) begin
            et = steps; ej = 1;
        end else begin
            et = (steps * inc1) / mod1; ej = (mod1 + inc1 - 1) / inc1;
        end
        ef = (ej * d <= m) ? ej * d : 0;
        first = 0; nt = 0; ns = 0; bad = 0;
        for (int i = 1; i <= m; i++) begin
            @(negedge clk);
            if (tick) begin
                nt++;
                if (first == 0) first = i;
            end
            if (stb) begin
                ns++;
                if (!tick) bad++;
            end
        end
        chk(first == ef, {tag, " first tick (R7)"}, first, ef);
        chk(nt == et, {tag, " tick count (R3)"}, nt, et);
        chk(ns == et / 16, {tag, " strobe count (R4)"}, ns, et / 16);
        chk(bad == 0, {tag, " strobe without tick (R4)"}, bad, 0);
    endtask

    initial begin
        int wd = 0;
        while (wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fs, nt, ns;
        idle(3);
        chk(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
        chk(stb == 1'b0, "R1 strobe low in reset", int'(stb), 0);
        rst_n = 1'b1;

        // R1: defaults, exact spacing and first strobe position
        fs = 0; nt = 0; ns = 0;
        for (int i = 1; i <= 416; i++) begin
            @(negedge clk);
            if (tick) begin
                nt++;
                if (i % 13 != 0) chk(0, "R1 tick spacing", i, (i / 13) * 13);
            end
            if (stb && fs == 0) fs = i;
        end
        chk(nt == 32, "R1 tick count", nt, 32);
        chk(fs == 208, "R1 first bit strobe", fs, 208);

        // R5: lone modulus write changes nothing; restart via code write
        strobe(2, 50);
        strobe(0, 5);
        measure(416, "R5 lone modulus");

        // R6: increment then predivider write cancels the pair
        strobe(1, 3);
        strobe(0, 5);
        measure(416, "R6 cancelled pair");
        strobe(2, 9);
        strobe(0, 5);
        measure(416, "R6 late modulus");

        // R5: proper pair with idle cycles between the writes
        strobe(1, 3);
        idle(4);
        strobe(2, 9);
        m_inc = 3; m_mod = 9;
        measure(500, "R5 pair commit");

        // R5: restaged increment, last value committed
        strobe(1, 0);
        strobe(1, 1);
        strobe(2, 4);
        m_inc = 1; m_mod = 4;
        measure(400, "R5 restaged increment");

        // R2 / R8: sweep every predivider code with inc1=4, mod1=10
        strobe(1, 3);
        strobe(2, 9);
        m_inc = 3; m_mod = 9;
        for (int c = 0; c < 8; c++) begin
            strobe(0, c);
            m_code = c;
            measure(700, $sformatf("R2 R8 code %0d", c));
        end

        // R3: several ratios at divide 1
        strobe(0, 5);
        m_code = 5;
        for (int k = 0; k < 5; k++) begin
            int iv [5] = '{0, 4, 7, 2, 15};
            int mv [5] = '{0, 6, 7, 12, 16};
            strobe(1, iv[k]);
            strobe(2, mv[k]);
            m_inc = iv[k]; m_mod = mv[k];
            measure(400, $sformatf("R3 ratio %0d/%0d", iv[k] + 1, mv[k] + 1));
        end

        // R9: increment above modulus, one tick per predivided clock
        strobe(1, 9);
        strobe(2, 3);
        m_inc = 9; m_mod = 3;
        measure(300, "R9 saturated div1");
        strobe(0, 0);
        m_code = 0;
        measure(300, "R9 saturated div6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule